// File: doc/BRIEF.md
# Boot Image MAC Checker

This block checks a region of boot memory before the application is allowed to run. Once reset is released, it reads the region one 128-bit block at a time. It folds each block into a running digest with a Miyaguchi-Preneel step: the running digest serves as the cipher key, the block serves as the plaintext, and the cipher output is XORed with both of them. The block cipher sits outside this block and is reached through a request/acknowledge handshake. The first chaining value comes from a dedicated boot-MAC key input.

When the last block has been folded in, the digest is compared with a stored 128-bit reference. A match raises `pass`. A mismatch raises `key_lock`, which the surrounding system uses to freeze its key store. Both verdicts, and `done`, hold until the next reset. The region base and its length in blocks are inputs that must stay stable while the check runs.

The per-block cost is a fixed three cycles plus whatever wait states the memory and the cipher add. This keeps a 128 KB region inside a 10 ms window at ordinary clock rates.

Top module: `bootmac_seq`

## Requirements
- R1: While reset is held, `done`, `pass`, `key_lock`, `mem_req` and `cph_req` are 0. With `AUTO_START`=1 (the default), a check begins on the first clock edge after reset is released, and no trigger is needed.
- R2: For a length of N blocks, exactly N memory reads are made, at block addresses `base_addr`, `base_addr`+1, … `base_addr`+N-1 in that order. The address wraps modulo 2^ADDR_W.
- R3: `mem_req` stays high with `mem_addr` unchanged until the cycle in which `mem_valid` is seen high.
- R4: For block i, the cipher request carries the chaining value H(i-1) on `cph_key` and the block on `cph_data`, with H(0) = `boot_key`. The request and its operands stay unchanged until `cph_ack`, and the next read starts only after the acknowledge.
- R5: Each step computes H(i) = `cph_result` XOR block XOR H(i-1).
- R6: After the last step, `done` rises. `pass` is 1 if the final digest equals `ref_mac`; otherwise `key_lock` is 1. Exactly one of the two is set while `done` is high.
- R7: A length of zero compares `boot_key` directly with `ref_mac` and issues no read and no cipher request.
- R8: `done`, `pass` and `key_lock` hold their values until the next reset, and no memory read or cipher request is issued after `done`.
- R9: With `AUTO_START`=1, a `start` pulse during a check or after `done` has no effect: the read sequence, the verdict and the completion time are unchanged.
- R10: With `mem_valid` arriving W_m cycles after a read request and `cph_ack` arriving W_c cycles after a cipher request, `done` is first high after 3N+2+N·(W_m+W_c) rising edges counted from reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Trigger pulse, used only when AUTO_START=0 |
| base_addr | input | ADDR_W | First block address of the region |
| blk_count | input | LEN_W | Region length in 128-bit blocks |
| boot_key | input | BLK_W | Boot-MAC key, initial chaining value |
| ref_mac | input | BLK_W | Expected digest |
| mem_req | output | 1 | Block read request |
| mem_addr | output | ADDR_W | Block address being read |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | BLK_W | Read data |
| cph_req | output | 1 | Cipher request |
| cph_key | output | BLK_W | Cipher key (chaining value) |
| cph_data | output | BLK_W | Cipher plaintext (current block) |
| cph_ack | input | 1 | Cipher result valid |
| cph_result | input | BLK_W | Cipher output |
| busy | output | 1 | Check in progress |
| done | output | 1 | Check finished (sticky) |
| pass | output | 1 | Digest matched (sticky) |
| key_lock | output | 1 | Digest mismatched, keys locked (sticky) |

## Verification
The situation hardest to reach from the ports is a stalled handshake: a read or cipher request left waiting for several cycles while its operands must stay frozen. Getting the cycle count wrong here would also move the completion time. The bench drives both responders with programmable wait counts and sweeps region lengths from zero to five blocks with every wait combination, including a base address that wraps. For each run it checks the chaining values seen on the cipher port against an arithmetic model, checks the completion cycle against the latency formula, and checks both a matching and a corrupted reference. Start pulses are injected mid-run and after completion to show that they have no effect.

// File: rtl/bootmac_seq.sv
module bootmac_seq #(
  parameter int BLK_W      = 128,
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 16,
  parameter bit AUTO_START = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  blk_count,
  input  logic [BLK_W-1:0]  boot_key,
  input  logic [BLK_W-1:0]  ref_mac,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [BLK_W-1:0]  mem_rdata,
  output logic              cph_req,
  output logic [BLK_W-1:0]  cph_key,
  output logic [BLK_W-1:0]  cph_data,
  input  logic              cph_ack,
  input  logic [BLK_W-1:0]  cph_result,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              key_lock
);

  typedef enum logic [2:0] {IDLE, FETCH, CIPHER, FOLD, COMPARE, DONE} state_t;

  state_t             st;
  logic [BLK_W-1:0]   h, m, e;
  logic [LEN_W-1:0]   idx;
  logic               go;

  assign go       = AUTO_START | start;
  assign mem_req  = (st == FETCH);
  assign mem_addr = base_addr + ADDR_W'(idx);
  assign cph_req  = (st == CIPHER);
  assign cph_key  = h;
  assign cph_data = m;
  assign busy     = (st != IDLE) && (st != DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      h        <= '0;
      m        <= '0;
      e        <= '0;
      idx      <= '0;
      done     <= 1'b0;
      pass     <= 1'b0;
      key_lock <= 1'b0;
    end else begin
      case (st)
        IDLE: if (go) begin
          h   <= boot_key;
          idx <= '0;
          st  <= (blk_count == '0) ? COMPARE : FETCH;
        end
        FETCH: if (mem_valid) begin
          m  <= mem_rdata;
          st <= CIPHER;
        end
        CIPHER: if (cph_ack) begin
          e  <= cph_result;
          st <= FOLD;
        end
        FOLD: begin
          h   <= e ^ m ^ h;
          idx <= idx + LEN_W'(1);
          st  <= ((idx + LEN_W'(1)) == blk_count) ? COMPARE : FETCH;
        end
        COMPARE: begin
          done     <= 1'b1;
          pass     <= (h == ref_mac);
          key_lock <= (h != ref_mac);
          st       <= DONE;
        end
        default: st <= DONE;
      endcase
    end
  end

  // R3: read request and address held until data arrives
  a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  // R4: cipher request and operands held until acknowledged
  a_r4_cph_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cph_req && !cph_ack |=> cph_req && $stable(cph_key) && $stable(cph_data));

  // R6: exactly one verdict once finished
  a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != key_lock));

  // R8: verdict sticky, interfaces quiet after completion
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(pass) && $stable(key_lock));

  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req && !cph_req && !busy);

  // R6: verdict only appears with done
  a_r6_no_early_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !pass && !key_lock);

endmodule

// File: tb/sim_bootmac_seq.sv
module sim_bootmac_seq;
  localparam int BW = 128, AW = 16, LW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [LW-1:0] blk_count = '0;
  logic [BW-1:0] boot_key = '0, ref_mac = '0;
  logic mem_req, mem_valid, cph_req, cph_ack, busy, done, pass, key_lock;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_rdata, cph_key, cph_data, cph_result;

  int checks = 0, errors = 0;
  int mw = 0, cw = 0, mcnt = 0, ccnt = 0;
  int rd_cnt = 0, ck_cnt = 0, chain_err = 0;
  logic [BW-1:0] mh;

  always #2.5 clk = ~clk;

  function automatic logic [BW-1:0] mword(input logic [AW-1:0] a);
    logic [31:0] x = {16'h0, a};
    return {x * 32'h9E3779B9, ~x ^ 32'h5A5A0000, x + 32'h1234, 32'hC0DE0000 | x};
  endfunction

  function automatic logic [BW-1:0] perm(input logic [BW-1:0] k, input logic [BW-1:0] x);
    logic [BW-1:0] t = x ^ k;
    t = {t[114:0], t[127:115]};
    return t + {k[63:0], k[127:64]};
  endfunction

  function automatic logic [BW-1:0] digest(input logic [AW-1:0] b, input int n, input logic [BW-1:0] k);
    logic [BW-1:0] hv = k;
    for (int i = 0; i < n; i++) begin
      logic [BW-1:0] w = mword(b + AW'(i));
      hv = perm(hv, w) ^ w ^ hv;
    end
    return hv;
  endfunction

  assign mem_valid  = mem_req && (mcnt == mw);
  assign mem_rdata  = mword(mem_addr);
  assign cph_ack    = cph_req && (ccnt == cw);
  assign cph_result = perm(cph_key, cph_data);

  always @(posedge clk) begin
    mcnt <= (mem_req && !mem_valid) ? mcnt + 1 : 0;
    ccnt <= (cph_req && !cph_ack) ? ccnt + 1 : 0;
  end

  always @(negedge clk) if (rst_n) begin
    if (mem_req && mem_valid) begin
      if (mem_addr != base_addr + AW'(rd_cnt)) chain_err++;
      rd_cnt++;
    end
    if (cph_req && cph_ack) begin
      if (cph_key != mh || cph_data != mword(base_addr + AW'(ck_cnt))) chain_err++;
      mh = perm(mh, cph_data) ^ cph_data ^ mh;
      ck_cnt++;
    end
  end

  bootmac_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .blk_count(blk_count), .boot_key(boot_key), .ref_mac(ref_mac),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .cph_req(cph_req), .cph_key(cph_key), .cph_data(cph_data), .cph_ack(cph_ack),
    .cph_result(cph_result), .busy(busy), .done(done), .pass(pass), .key_lock(key_lock));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [AW-1:0] b, input int n, input bit good, input int m_w, input int c_w);
    int cyc = 0, exp_lat;
    logic [BW-1:0] dg;
    @(negedge clk);
    rst_n = 1'b0;
    base_addr = b; blk_count = LW'(n); mw = m_w; cw = c_w;
    boot_key = {32'h0B00_7000 + n, 32'hA5A5_0000 | 32'(b), 32'h1357_9BDF, 32'h2468_ACE0};
    dg = digest(b, n, boot_key);
    ref_mac = good ? dg : dg ^ (BW'(1) << (n * 7));
    rd_cnt = 0; ck_cnt = 0; chain_err = 0; mh = boot_key;
    repeat (2) @(negedge clk);
    chk(!done && !pass && !key_lock && !mem_req && !cph_req, "R1 reset state",
        int'({done, pass, key_lock, mem_req, cph_req}), 0);
    rst_n = 1'b1;
    exp_lat = 3 * n + 2 + n * (m_w + c_w);
    while (cyc < 2000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      start = (cyc == 3);
      if (done) break;
    end
    start = 1'b0;
    chk(done, "R1 completion (watchdog)", int'(done), 1);
    chk(cyc == exp_lat, "R10 latency / R9 start ignored mid-run", cyc, exp_lat);
    chk(rd_cnt == n, "R2 read count", rd_cnt, n);
    chk(ck_cnt == n, "R4 cipher request count", ck_cnt, n);
    chk(chain_err == 0, "R4 R5 chaining operands", chain_err, 0);
    if (n == 0) chk(rd_cnt == 0 && ck_cnt == 0, "R7 zero-length no traffic", rd_cnt + ck_cnt, 0);
    chk(pass == good && key_lock == !good, good ? "R6 pass on match" : "R6 lock on mismatch",
        int'({pass, key_lock}), good ? 2 : 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    chk(done && pass == good && key_lock == !good && rd_cnt == n && !mem_req && !cph_req,
        "R8 R9 sticky, start after done ignored", int'({done, pass, key_lock}), good ? 6 : 5);
  endtask

  initial begin
    for (int n = 0; n <= 5; n++)
      for (int g = 0; g < 2; g++)
        for (int a = 0; a < 2; a++)
          for (int c = 0; c < 2; c++)
            run(AW'(n * 7 + 3), n, g[0], a * 2, c * 3);
    run(16'hFFFE, 4, 1'b1, 1, 1);
    run(16'hFFFE, 4, 1'b0, 0, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule